// File: doc/BRIEF.md
# Data EEPROM Erase Controller

This block holds a small data EEPROM as an array of 16-bit words and erases parts of it on command from software. Software sees five registers on a simple write bus with a combinational read path: a control register, a page register, an offset register, an unlock key register and a completion status register. The page and offset registers together form the word address of the erase.

An erase starts only when a fixed two-byte key has been written to the key register just before the control write that sets the start bit. The erase covers one, four or eight words, or the whole array. It writes the blank value into one word per clock cycle. While it runs, the start bit reads back as 1. When the last word is blank, the start bit reads 0 again and a sticky completion flag is raised on the interrupt output. A separate read port lets the array contents be observed word by word.

Top module: `ee_erase_ctrl`

## Requirements
- R1: After reset, the control register and the status register read 0, `irq` is 0, and array word i holds {i[7:0], ~i[7:0]}, so word 0 reads 0x00FF and word 13 reads 0x0DF2.
- R2: Bits [1:0] of the control value that starts an erase choose its size: 00 erases one word, 01 four words, 10 eight words and 11 the whole array.
- R3: The erase address is page * 2^OFFS_W + offset, taken from register select 1 (page) and register select 2 (offset). For four-word and eight-word erases it is aligned down to a multiple of the size. A whole-array erase starts at word 0.
- R4: An erase starts when three bus writes arrive back to back: 0x55 to the key register (select 3), then 0xAA to the key register, then a control write (select 0) with bit 15 (start), bit 14 (write enable) and bit 6 (erase mode) set. For example, 0xC058 starts a one-word erase.
- R5: A control write that sets the start bit without the full key directly before it is ignored and leaves the array unchanged. This includes a key sequence broken by any other bus write.
- R6: Control bit 15 reads 1 for exactly N clock cycles after the starting write, where N is the erase size in words, and then reads 0.
- R7: When an erase completes, status bit 0 and `irq` go to 1 and stay there until software writes status (select 4) with bit 0 = 0.
- R8: Control register writes are ignored while bit 15 reads 1. After completion, the control register reads back the starting value with bit 15 cleared.
- R9: Every word inside the erase range reads 0xFFFF afterwards, and every word outside it keeps its value.
- R10: A start that is unlocked correctly but whose value lacks bit 14 or bit 6 does not start an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_sel | input | 3 | Register select: 0 control, 1 page, 2 offset, 3 key, 4 status |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the register chosen by bus_sel |
| rd_addr | input | PAGE_W+OFFS_W | Array read word address |
| rd_data | output | 16 | Array word at rd_addr |
| irq | output | 1 | Sticky erase-complete flag |

## Verification
The erase is run once for each size, each time from an address that is not aligned, so a misaligned start or a wrong word count shows up in the neighbouring words just outside the range. The cycle count of the start bit is measured for every size, which separates one-word-per-cycle sequencing from an early or late finish. Unlock handling is tried with no key, with a key broken by a page write, and with a correct key but missing enable bits. Each of these must leave the array and the start bit untouched. A control write made during an eight-word erase checks that the running operation is protected.

// File: rtl/ee_erase_pkg.sv
package ee_erase_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_PAGE = 3'd1,
        SEL_OFFS = 3'd2,
        SEL_KEY  = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_ONE   = 2'b00,
        OP_FOUR  = 2'b01,
        OP_EIGHT = 2'b10,
        OP_ALL   = 2'b11
    } erase_op_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_st_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_ERASE = 6;

    localparam logic [DATA_W-1:0] BLANK_WORD = '1;

    function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
        logic [7:0] b;
        b = idx[7:0];
        return {b, ~b};
    endfunction

    function automatic int unsigned op_words(input erase_op_e op, input int unsigned total);
        case (op)
            OP_ONE:   return 1;
            OP_FOUR:  return 4;
            OP_EIGHT: return 8;
            default:  return total;
        endcase
    endfunction

endpackage

// File: rtl/ee_erase_unlock.sv
module ee_erase_unlock
    import ee_erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              armed
);

    unlock_st_e st_q, st_d;
    logic       is_key;

    assign is_key = (bus_sel == SEL_KEY);
    assign armed  = (st_q == UL_ARMED);

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (is_key && bus_wdata[7:0] == KEY_FIRST)
                st_d = UL_HALF;
            else if (st_q == UL_HALF && is_key && bus_wdata[7:0] == KEY_SECOND)
                st_d = UL_ARMED;
            else
                st_d = UL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UL_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/ee_erase_seq.sv
module ee_erase_seq
    import ee_erase_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  erase_op_e     op,
    input  logic [AW-1:0] base,
    output logic          busy,
    output logic          done,
    output logic          we,
    output logic [AW-1:0] waddr
);

    localparam int WORDS = 1 << AW;
    localparam int LW    = $clog2(WORDS + 1);

    logic [AW-1:0] ptr_q;
    logic [LW-1:0] left_q;
    logic          busy_q;
    logic [LW-1:0] size_w;
    logic [AW-1:0] align_mask;

    always_comb begin
        size_w     = LW'(op_words(op, WORDS));
        align_mask = ~(AW'(size_w - LW'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
            left_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            ptr_q  <= base & align_mask;
            left_q <= size_w;
        end else if (busy_q) begin
            ptr_q  <= ptr_q + AW'(1);
            left_q <= left_q - LW'(1);
            if (left_q == LW'(1)) busy_q <= 1'b0;
        end
    end

    assign busy  = busy_q;
    assign done  = busy_q && (left_q == LW'(1));
    assign we    = busy_q;
    assign waddr = ptr_q;

endmodule

// File: rtl/ee_erase_array.sv
module ee_erase_array
    import ee_erase_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= reset_word(i);
        end else if (we) begin
            cells[waddr] <= BLANK_WORD;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ee_erase_ctrl.sv
module ee_erase_ctrl
    import ee_erase_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int OFFS_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [2:0]               bus_sel,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic [PAGE_W+OFFS_W-1:0] rd_addr,
    output logic [15:0]              rd_data,
    output logic                     irq
);

    localparam int AW = PAGE_W + OFFS_W;

    logic [DATA_W-2:0] ctrl_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFFS_W-1:0] offs_q;
    logic              flag_q;
    logic              armed;
    logic              busy;
    logic              done;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic              ctrl_wr;
    logic              start;

    assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);
    assign start   = ctrl_wr && !busy && armed &&
                     bus_wdata[BIT_START] && bus_wdata[BIT_WREN] && bus_wdata[BIT_ERASE];

    ee_erase_unlock u_unlock (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    ee_erase_seq #(.AW(AW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (erase_op_e'(bus_wdata[1:0])),
        .base  ({page_q, offs_q}),
        .busy  (busy),
        .done  (done),
        .we    (mem_we),
        .waddr (mem_waddr)
    );

    ee_erase_array #(.AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            page_q <= '0;
            offs_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr && !busy) ctrl_q <= bus_wdata[DATA_W-2:0];
            if (bus_wr && bus_sel == SEL_PAGE) page_q <= bus_wdata[PAGE_W-1:0];
            if (bus_wr && bus_sel == SEL_OFFS) offs_q <= bus_wdata[OFFS_W-1:0];
            if (done)
                flag_q <= 1'b1;
            else if (bus_wr && bus_sel == SEL_STAT && !bus_wdata[0])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_sel)
            SEL_CTRL: bus_rdata = {busy, ctrl_q};
            SEL_PAGE: bus_rdata = 16'(page_q);
            SEL_OFFS: bus_rdata = 16'(offs_q);
            SEL_STAT: bus_rdata = {15'd0, flag_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = flag_q;

endmodule

// File: rtl/ee_erase_ctrl_chk.sv
module ee_erase_ctrl_chk #(
    parameter int WORDS = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [2:0]  bus_sel,
    input logic [15:0] bus_wdata,
    input logic        irq,
    input logic        busy,
    input logic        armed,
    input logic        mem_we,
    input logic [14:0] ctrl_q
);

    localparam int CW = $clog2(WORDS + 2);
    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + CW'(1);
        else           run_len <= '0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !irq));

    a_r4_start_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed && bus_wr && bus_sel == 3'd0 && bus_wdata[15]));

    a_r5_no_start_unarmed: assert property (@(posedge clk) disable iff (rst)
        (!armed && !busy) |=> !busy);

    a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_len <= CW'(WORDS));

    a_r7_done_raises_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctrl_q));

    a_r9_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

endmodule

bind ee_erase_ctrl ee_erase_ctrl_chk #(.WORDS(1 << (PAGE_W + OFFS_W))) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .busy      (busy),
    .armed     (armed),
    .mem_we    (mem_we),
    .ctrl_q    (ctrl_q)
);

// File: tb/test_ee_erase_ctrl.sv
module test_ee_erase_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W = 2;
    localparam int OFFS_W = 3;
    localparam int AW     = PAGE_W + OFFS_W;
    localparam int WORDS  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_sel = 3'd0;
    logic [15:0]   bus_wdata = 16'd0;
    logic [15:0]   bus_rdata;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [15:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_erase_ctrl #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) i_ee_erase_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] sel, input logic [15:0] data);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] sel, output logic [15:0] data);
        bus_sel = sel; #1; data = bus_rdata;
    endtask

    task automatic check_array(input string tag);
        int bad = 0;
        for (int i = 0; i < WORDS; i++) begin
            rd_addr = AW'(i); #1;
            if (rd_data !== model[i]) begin
                bad++;
                check(0, $sformatf("%s word %0d", tag, i), rd_data, model[i]);
            end
        end
        if (bad == 0) check(1, tag, 0, 0);
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] v;
        n = 0;
        bus_read(3'd0, v);
        while (v[15]) begin
            @(negedge clk); n++;
            bus_read(3'd0, v);
        end
    endtask

    task automatic unlock_and_start(input int page, input int offs, input logic [15:0] ctl);
        bus_write(3'd1, 16'(page));
        bus_write(3'd2, 16'(offs));
        bus_write(3'd3, 16'h0055);
        bus_write(3'd3, 16'h00AA);
        bus_write(3'd0, ctl);
    endtask

    task automatic clear_flag();
        logic [15:0] v;
        bus_write(3'd4, 16'h0000);
        bus_read(3'd4, v);
        check(v == 0 && irq == 0, "R7 flag clear", {irq, v[0]}, 0);
    endtask

    task automatic model_erase(input int first, input int cnt);
        for (int i = first; i < first + cnt; i++) model[i] = 16'hFFFF;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        bus_read(3'd0, v); check(v == 0, "R1 ctrl reset", v, 0);
        bus_read(3'd4, v); check(v == 0, "R1 status reset", v, 0);
        check(irq == 0, "R1 irq reset", irq, 0);
        rd_addr = AW'(13); #1;
        check(rd_data == 16'h0DF2, "R1 word 13", rd_data, 16'h0DF2);
        check_array("R1 array pattern");
    endtask

    task automatic t_no_key();
        logic [15:0] v;
        bus_write(3'd1, 16'd1);
        bus_write(3'd2, 16'd2);
        bus_write(3'd0, 16'hC058);
        bus_read(3'd0, v);
        check(v[15] == 0, "R5 start without key", v[15], 0);
        repeat (3) @(negedge clk);
        check_array("R5 array untouched no key");
    endtask

    task automatic t_broken_key();
        logic [15:0] v;
        bus_write(3'd3, 16'h0055);
        bus_write(3'd1, 16'd0);
        bus_write(3'd3, 16'h00AA);
        bus_write(3'd0, 16'hC058);
        bus_read(3'd0, v);
        check(v[15] == 0, "R5 R4 broken key", v[15], 0);
        repeat (3) @(negedge clk);
        check_array("R5 array untouched broken key");
        check(irq == 0, "R5 no completion", irq, 0);
    endtask

    task automatic t_no_enable();
        logic [15:0] v;
        unlock_and_start(0, 0, 16'h8058);
        bus_read(3'd0, v);
        check(v[15] == 0, "R10 missing write enable", v[15], 0);
        unlock_and_start(0, 0, 16'hC018);
        bus_read(3'd0, v);
        check(v[15] == 0, "R10 missing erase bit", v[15], 0);
        repeat (2) @(negedge clk);
        check_array("R10 array untouched");
    endtask

    task automatic t_one();
        int n; logic [15:0] v;
        unlock_and_start(1, 5, 16'hC058);
        wait_idle(n);
        check(n == 1, "R6 R2 one-word cycles", n, 1);
        model_erase(13, 1);
        check_array("R9 R3 one-word range");
        bus_read(3'd4, v);
        check(v[0] == 1 && irq == 1, "R7 flag after one-word", irq, 1);
        bus_read(3'd0, v);
        check(v == 16'h4058, "R8 ctrl readback", v, 16'h4058);
        clear_flag();
    endtask

    task automatic t_four();
        int n;
        unlock_and_start(2, 6, 16'hC059);
        wait_idle(n);
        check(n == 4, "R6 R2 four-word cycles", n, 4);
        model_erase(20, 4);
        check_array("R9 R3 four-word aligned");
        check(irq == 1, "R7 irq four-word", irq, 1);
        clear_flag();
    endtask

    task automatic t_eight();
        int n; logic [15:0] v;
        unlock_and_start(0, 3, 16'hC05A);
        bus_write(3'd0, 16'h0000);
        bus_read(3'd0, v);
        check(v == 16'hC05A, "R8 ctrl write ignored while busy", v, 16'hC05A);
        wait_idle(n);
        check(n == 7, "R6 R2 eight-word cycles", n + 1, 8);
        bus_read(3'd0, v);
        check(v == 16'h405A, "R8 ctrl after eight-word", v, 16'h405A);
        model_erase(0, 8);
        check_array("R9 R3 eight-word aligned");
        clear_flag();
    endtask

    task automatic t_all();
        int n;
        unlock_and_start(3, 7, 16'hC05B);
        wait_idle(n);
        check(n == WORDS, "R6 R2 whole-array cycles", n, WORDS);
        model_erase(0, WORDS);
        check_array("R9 R3 whole array");
        check(irq == 1, "R7 irq whole array", irq, 1);
        clear_flag();
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = {8'(i), ~8'(i)};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_key();
        t_broken_key();
        t_no_enable();
        t_one();
        t_four();
        t_eight();
        t_all();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule